// File: doc/BRIEF.md
# Bus Adapter Control and Error Register Bank

This block is the register bank of a system-bus adapter. Software reaches it through a word-addressed port with separate read and write strobes. It holds a control word, a read-only configuration word, an error summary, a captured timeout address, a fault-status word, a silo-comparator word and a maintenance word. Each register applies its own read mask, write mask and write-one-to-clear mask. Every other index reads as zero and discards writes.

The block also decides whether a downstream transaction may go out. A request is granted only when forwarding is enabled and the addressed slot acknowledges. Any other request counts as a timeout. For the first timeout the block latches the word address and sets a flag. For later timeouts it only sets a sticky multiple-error bit. Error-confirm and corrected-read events feed the same error word. A corrected-read interrupt level is updated whenever software writes the error register.

Top module: `bus_adapter_csr`

## Requirements
- R1: After reset the control register reads 0x60000000 (forward enable at bit 30 and accept enable at bit 29 set, interrupt enable at bit 31 clear). Every other register reads 0, and crd_irq is low.
- R2: The register index is reg_addr[6:2]. Index 0 always reads 0x00400010 and ignores writes. Indices 2 to 12 and 0x12 to 0x1F read 0 and ignore writes.
- R3: Control register (index 1): a write loads wr_data bits 31:29 and discards all other bits, so a write of 0xFFFFFFFF reads back 0xE0000000.
- R4: Error register (index 0xD) reads through mask 0x0000FDFE. Only bit 15 (corrected-read interrupt enable) is loaded from write data. Writing 1 to a flag bit never sets it.
- R5: In the error register, writing 1 to any of bits 14, 13, 12, 7 or 6 clears that bit.
- R6: Writing 1 to error bit 12 also clears bits 11:10, bit 8 and bit 2. Writing 1 to bit 6 also clears bits 11:10 and bit 3.
- R7: On a timeout with error bit 12 clear, the block stores fwd_addr>>2 in the timeout-address register (index 0xE, read-only) and sets bit 12. On a timeout with bit 12 already set, it only sets bit 2 and keeps the stored address.
- R8: An err_confirm pulse sets error bit 8 if it is clear, and otherwise sets bit 2.
- R9: Fault register (index 0xF) reads through 0x031F0000, loads bits 0x03140000, and clears bit 19 when it is written with 1.
- R10: Silo register (index 0x10) reads through 0xFFFF0000 and loads bits 0x7FFF0000. Any write clears bit 31.
- R11: Maintenance register (index 0x11) reads through 0xFFFFFF00 and loads only bits 0xFFFFF900.
- R12: fwd_grant is high exactly when fwd_valid, control bit 30 and slot_ack are all high. A fwd_valid cycle without a grant is a timeout (R7).
- R13: A crd_evt pulse sets error bit 14. crd_irq changes only in the cycle after a write to index 0xD, and it then equals bit 15 AND bit 14 of the register value after that write.
- R14: rd_data takes the addressed register value in the cycle after reg_rd is high, and holds its value in every cycle where reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 7 | Byte address; bits 6:2 select the register |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| fwd_valid | input | 1 | Downstream transaction request |
| fwd_addr | input | 32 | Physical byte address of the request |
| slot_ack | input | 1 | Target slot present and responding |
| fwd_grant | output | 1 | Transaction forwarded |
| err_confirm | input | 1 | Error-confirm event pulse |
| crd_evt | input | 1 | Corrected-read event pulse |
| crd_irq | output | 1 | Corrected-read interrupt level |

## Verification
The bench checks the following corner cases:
- A second timeout. A design that overwrites the captured address on this event reports the wrong failing word.
- A second confirm event. A design that loses the sticky bit 2 here fails the check.
- The grouped clear. Writing 1 to bit 12 alone must also clear the confirm and multiple-error bits. A design that clears only the bit written leaves them set.
- Timeouts with forwarding disabled while the slot acknowledges. A design that checks only slot_ack grants the request.
- crd_irq after a corrected-read event that arrives with no register write. A design that tracks the flags continuously raises the interrupt too early.
- Writes of all ones to every masked register. These expose a wrong write mask or read mask bit by bit.

// File: rtl/bacsr_pkg.sv
package bacsr_pkg;
  localparam int unsigned DW = 32;

  localparam logic [4:0] IX_CFG   = 5'h00;
  localparam logic [4:0] IX_CTRL  = 5'h01;
  localparam logic [4:0] IX_ERR   = 5'h0D;
  localparam logic [4:0] IX_TADDR = 5'h0E;
  localparam logic [4:0] IX_FAULT = 5'h0F;
  localparam logic [4:0] IX_SILO  = 5'h10;
  localparam logic [4:0] IX_MAINT = 5'h11;

  localparam logic [DW-1:0] CFG_WORD = 32'h0040_0010;

  // error word layout
  localparam int unsigned EB_CRDIE = 15;
  localparam int unsigned EB_CRD   = 14;
  localparam int unsigned EB_TMO   = 12;
  localparam int unsigned EB_CNF   = 8;
  localparam int unsigned EB_IBT   = 6;
  localparam int unsigned EB_MULT  = 2;
  localparam logic [DW-1:0] ERR_RMASK = 32'h0000_FDFE;
  localparam logic [DW-1:0] ERR_WMASK = 32'h0000_8000;
  localparam logic [DW-1:0] ERR_W1C   = 32'h0000_70C0;
  localparam logic [DW-1:0] ERR_TGRP  = 32'h0000_1D04;
  localparam logic [DW-1:0] ERR_IGRP  = 32'h0000_0C48;

  // plain masked registers: 0 ctrl, 1 fault, 2 silo, 3 maint
  localparam int unsigned NMREG = 4;
  localparam logic [NMREG-1:0][DW-1:0] MR_WMASK =
    {32'hFFFF_F900, 32'h7FFF_0000, 32'h0314_0000, 32'hE000_0000};
  localparam logic [NMREG-1:0][DW-1:0] MR_W1C =
    {32'h0000_0000, 32'h0000_0000, 32'h0008_0000, 32'h0000_0000};
  localparam logic [NMREG-1:0][DW-1:0] MR_CLRW =
    {32'h0000_0000, 32'h8000_0000, 32'h0000_0000, 32'h0000_0000};
  localparam logic [NMREG-1:0][DW-1:0] MR_RMASK =
    {32'hFFFF_FF00, 32'hFFFF_0000, 32'h031F_0000, 32'hE000_0000};
  localparam logic [NMREG-1:0][DW-1:0] MR_RST =
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h6000_0000};
  localparam logic [NMREG-1:0][4:0] MR_IDX =
    {IX_MAINT, IX_SILO, IX_FAULT, IX_CTRL};
endpackage

// File: rtl/bacsr_mreg.sv
module bacsr_mreg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] WMASK = '0,
  parameter logic [W-1:0] W1C   = '0,
  parameter logic [W-1:0] CLRW  = '0,
  parameter logic [W-1:0] RSTV  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= RSTV;
    else if (we)
      q <= ((q & ~(WMASK | CLRW)) | (wdata & WMASK)) & ~(wdata & W1C);
  end
endmodule

// File: rtl/bacsr_err_unit.sv
module bacsr_err_unit
  import bacsr_pkg::*;
#(
  parameter int unsigned PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [DW-1:0]   wdata,
  input  logic            tmo_evt,
  input  logic [PA_W-1:0] tmo_pa,
  input  logic            cnf_evt,
  input  logic            crd_evt,
  output logic [DW-1:0]   er_q,
  output logic [DW-1:0]   ta_q,
  output logic            crd_irq
);
  logic [DW-1:0] er_w, er_n, ta_n;

  // software write first, then hardware events on the written value
  always_comb begin
    er_w = er_q;
    if (we) begin
      er_w = (er_q & ~ERR_WMASK) | (wdata & ERR_WMASK);
      er_w = er_w & ~(wdata & ERR_W1C);
      if (wdata[EB_TMO]) er_w = er_w & ~ERR_TGRP;
      if (wdata[EB_IBT]) er_w = er_w & ~ERR_IGRP;
    end
    er_n = er_w;
    ta_n = ta_q;
    if (tmo_evt) begin
      if (!er_w[EB_TMO]) begin
        er_n[EB_TMO] = 1'b1;
        ta_n = DW'(tmo_pa >> 2);
      end else begin
        er_n[EB_MULT] = 1'b1;
      end
    end
    if (cnf_evt) begin
      if (!er_n[EB_CNF]) er_n[EB_CNF] = 1'b1;
      else               er_n[EB_MULT] = 1'b1;
    end
    if (crd_evt) er_n[EB_CRD] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      er_q    <= '0;
      ta_q    <= '0;
      crd_irq <= 1'b0;
    end else begin
      er_q <= er_n;
      ta_q <= ta_n;
      if (we) crd_irq <= er_w[EB_CRDIE] & er_w[EB_CRD];
    end
  end
endmodule

// File: rtl/bus_adapter_csr.sv
module bus_adapter_csr
  import bacsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned PA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic              fwd_valid,
  input  logic [PA_W-1:0]   fwd_addr,
  input  logic              slot_ack,
  output logic              fwd_grant,
  input  logic              err_confirm,
  input  logic              crd_evt,
  output logic              crd_irq
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned CTRL_SLOT = 0;
  localparam int unsigned FWD_EN_BIT = 30;

  logic [IDX_W-1:0] idx;
  logic [NMREG-1:0][DW-1:0] mr_q;
  logic [DW-1:0] er_q, ta_q, rd_n;
  logic tmo_evt;

  assign idx = reg_addr[ADDR_W-1:2];

  for (genvar g = 0; g < NMREG; g++) begin : g_mreg
    bacsr_mreg #(
      .W(DW), .WMASK(MR_WMASK[g]), .W1C(MR_W1C[g]),
      .CLRW(MR_CLRW[g]), .RSTV(MR_RST[g])
    ) u_reg (
      .clk(clk), .rst_n(rst_n),
      .we(reg_wr && (idx == IDX_W'(MR_IDX[g]))),
      .wdata(wr_data), .q(mr_q[g])
    );
  end

  assign fwd_grant = fwd_valid & mr_q[CTRL_SLOT][FWD_EN_BIT] & slot_ack;
  assign tmo_evt   = fwd_valid & ~fwd_grant;

  bacsr_err_unit #(.PA_W(PA_W)) u_err (
    .clk(clk), .rst_n(rst_n),
    .we(reg_wr && (idx == IDX_W'(IX_ERR))),
    .wdata(wr_data),
    .tmo_evt(tmo_evt), .tmo_pa(fwd_addr),
    .cnf_evt(err_confirm), .crd_evt(crd_evt),
    .er_q(er_q), .ta_q(ta_q), .crd_irq(crd_irq)
  );

  always_comb begin
    rd_n = '0;
    if (idx == IDX_W'(IX_CFG))   rd_n = CFG_WORD;
    if (idx == IDX_W'(IX_ERR))   rd_n = er_q & ERR_RMASK;
    if (idx == IDX_W'(IX_TADDR)) rd_n = ta_q;
    for (int i = 0; i < NMREG; i++)
      if (idx == IDX_W'(MR_IDX[i])) rd_n = mr_q[i] & MR_RMASK[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (reg_rd) rd_data <= rd_n;
  end
endmodule

// File: rtl/bacsr_checker.sv
module bacsr_checker #(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [31:0]       rd_data,
  input logic              fwd_valid,
  input logic              slot_ack,
  input logic              fwd_grant,
  input logic              crd_irq
);
  logic [ADDR_W-3:0] idx;
  assign idx = reg_addr[ADDR_W-1:2];

  AST_CFG_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && idx == 0) |=> rd_data == 32'h0040_0010); // R2
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && idx >= 2 && idx <= 12) |=> rd_data == 32'h0); // R2
  AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && idx == 1) |=> rd_data[28:0] == '0); // R3
  AST_ERR_RMASK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && idx == 13) |=> (rd_data & ~32'h0000_FDFE) == '0); // R4
  AST_GRANT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_grant |-> (fwd_valid && slot_ack)); // R12
  AST_IRQ_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && idx == 13) |=> $stable(crd_irq)); // R13
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(rd_data)); // R14
endmodule

bind bus_adapter_csr bacsr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .reg_wr(reg_wr), .rd_data(rd_data), .fwd_valid(fwd_valid),
  .slot_ack(slot_ack), .fwd_grant(fwd_grant), .crd_irq(crd_irq)
);

// File: tb/bus_adapter_csr_bench.sv
module bus_adapter_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic        fwd_valid = 1'b0, slot_ack = 1'b0, fwd_grant;
  logic [31:0] fwd_addr = '0;
  logic        err_confirm = 1'b0, crd_evt = 1'b0, crd_irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_adapter_csr u_bus_adapter_csr (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .wr_data(wr_data), .rd_data(rd_data),
    .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .slot_ack(slot_ack),
    .fwd_grant(fwd_grant), .err_confirm(err_confirm), .crd_evt(crd_evt),
    .crd_irq(crd_irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] ix, logic [31:0] d);
    @(negedge clk);
    reg_addr = {ix, 2'b00}; wr_data = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [4:0] ix, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = {ix, 2'b00}; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    check(tag, rd_data, exp);
  endtask

  task automatic fwd(logic [31:0] pa, logic ack, logic exp_grant, string tag);
    @(negedge clk);
    fwd_addr = pa; slot_ack = ack; fwd_valid = 1'b1;
    #1 check(tag, {31'b0, fwd_grant}, {31'b0, exp_grant});
    @(negedge clk);
    fwd_valid = 1'b0; slot_ack = 1'b0;
  endtask

  task automatic pulse_cnf();
    @(negedge clk); err_confirm = 1'b1;
    @(negedge clk); err_confirm = 1'b0;
  endtask

  task automatic pulse_crd();
    @(negedge clk); crd_evt = 1'b1;
    @(negedge clk); crd_evt = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk(5'h01, 32'h6000_0000, "R1 ctrl reset");
    rd_chk(5'h0D, 32'h0, "R1 err reset");
    rd_chk(5'h0E, 32'h0, "R1 taddr reset");
    rd_chk(5'h10, 32'h0, "R1 silo reset");
    check("R1 crd_irq reset", {31'b0, crd_irq}, 32'h0);
  endtask

  task automatic t_cfg_unimpl();
    wr(5'h00, 32'hFFFF_FFFF);
    rd_chk(5'h00, 32'h0040_0010, "R2 cfg word");
    wr(5'h02, 32'hFFFF_FFFF);
    rd_chk(5'h02, 32'h0, "R2 idx2 zero");
    wr(5'h15, 32'hFFFF_FFFF);
    rd_chk(5'h15, 32'h0, "R2 idx15 zero");
  endtask

  task automatic t_ctrl();
    wr(5'h01, 32'hFFFF_FFFF);
    rd_chk(5'h01, 32'hE000_0000, "R3 ctrl all ones");
    wr(5'h01, 32'h8000_0001);
    rd_chk(5'h01, 32'h8000_0000, "R3 ctrl partial");
    wr(5'h01, 32'h6000_0000);
  endtask

  task automatic t_misc_masks();
    wr(5'h0F, 32'hFFFF_FFFF);
    rd_chk(5'h0F, 32'h0314_0000, "R9 fault masks");
    wr(5'h0F, 32'h0);
    rd_chk(5'h0F, 32'h0, "R9 fault cleared");
    wr(5'h10, 32'hFFFF_FFFF);
    rd_chk(5'h10, 32'h7FFF_0000, "R10 silo masks");
    wr(5'h11, 32'hFFFF_FFFF);
    rd_chk(5'h11, 32'hFFFF_F900, "R11 maint masks");
  endtask

  task automatic t_err_masks();
    wr(5'h0D, 32'hFFFF_FFFF);
    rd_chk(5'h0D, 32'h0000_8000, "R4 err only ie writable");
    wr(5'h0D, 32'h0);
    rd_chk(5'h0D, 32'h0, "R4 err ie cleared");
  endtask

  task automatic t_confirm();
    pulse_cnf();
    rd_chk(5'h0D, 32'h0000_0100, "R8 first confirm");
    pulse_cnf();
    rd_chk(5'h0D, 32'h0000_0104, "R8 second confirm mult");
    wr(5'h0D, 32'h0000_1000);
    rd_chk(5'h0D, 32'h0, "R6 tmo write clears cnf and mult");
  endtask

  task automatic t_timeout();
    fwd(32'h0000_1234, 1'b0, 1'b0, "R12 no ack no grant");
    rd_chk(5'h0D, 32'h0000_1000, "R7 tmo flag set");
    rd_chk(5'h0E, 32'h0000_048D, "R7 tmo addr captured");
    fwd(32'h0000_5678, 1'b0, 1'b0, "R12 second no grant");
    rd_chk(5'h0D, 32'h0000_1004, "R7 second tmo mult");
    rd_chk(5'h0E, 32'h0000_048D, "R7 addr kept");
    wr(5'h0E, 32'hFFFF_FFFF);
    rd_chk(5'h0E, 32'h0000_048D, "R7 taddr read-only");
    fwd(32'h0000_0009, 1'b1, 1'b1, "R12 grant when enabled and acked");
    rd_chk(5'h0D, 32'h0000_1004, "R12 grant leaves err");
    pulse_cnf();
    wr(5'h0D, 32'h0000_1000);
    rd_chk(5'h0D, 32'h0, "R6 group clear");
    fwd(32'h0000_5678, 1'b0, 1'b0, "R12 no grant after clear");
    rd_chk(5'h0E, 32'h0000_159E, "R7 recapture after clear");
    wr(5'h0D, 32'h0000_1000);
  endtask

  task automatic t_fwd_disabled();
    wr(5'h01, 32'h2000_0000);
    fwd(32'h0000_0400, 1'b1, 1'b0, "R12 disabled no grant");
    rd_chk(5'h0E, 32'h0000_0100, "R12 disabled tmo addr");
    rd_chk(5'h0D, 32'h0000_1000, "R12 disabled tmo flag");
    wr(5'h01, 32'h6000_0000);
    wr(5'h0D, 32'h0000_1000);
  endtask

  task automatic t_crd_irq();
    wr(5'h0D, 32'h0000_8000);
    pulse_crd();
    check("R13 irq waits for write", {31'b0, crd_irq}, 32'h0);
    rd_chk(5'h0D, 32'h0000_C000, "R13 crd flag set");
    wr(5'h0D, 32'h0000_8000);
    check("R13 irq after write", {31'b0, crd_irq}, 32'h1);
    wr(5'h0D, 32'h0000_C000);
    check("R13 irq drops after clear", {31'b0, crd_irq}, 32'h0);
    rd_chk(5'h0D, 32'h0000_8000, "R5 crd w1c");
    wr(5'h0D, 32'h0);
  endtask

  task automatic t_rd_hold();
    rd_chk(5'h00, 32'h0040_0010, "R14 read cfg");
    wr(5'h11, 32'h0);
    @(negedge clk);
    check("R14 rd_data held", rd_data, 32'h0040_0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg_unimpl();
    t_ctrl();
    t_misc_masks();
    t_err_masks();
    t_confirm();
    t_timeout();
    t_fwd_disabled();
    t_crd_irq();
    t_rd_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule